// File: doc/BRIEF.md
# Bank-Switched Upper Memory Controller

This block sits between an 8-bit CPU and its memories and translates each 16-bit CPU address into a physical RAM or ROM access. The window from $D000 to $FFFF can be read either from ROM or from RAM. Writes into that window can be blocked. The 4 KB page at $D000 is backed by one of two RAM banks, and bank 1 lives physically in the RAM page at $C000.

Three configuration flags control this mapping: a read source, a write lock and a bank choice. Software sets all three at once by touching one address in a 16-address soft-switch group at $C080–$C08F, with either a read or a write. The new setting is registered on the clock edge that ends the access, so every later access uses it. The flags are also brought out as outputs. RAM and ROM are external, with combinational read data. All other addresses pass straight through to RAM.

Top module: `upper_mem_ctrl`

## Requirements
- R1: With the bank flag showing bank 1 (`bank1`=1), an access to $D000–$DFFF drives RAM address $C000–$CFFF (same low 12 bits). With bank 2 selected (`bank1`=0), the RAM address equals the CPU address.
- R2: An access to $E000–$FFFF drives a RAM address equal to the CPU address, whatever the bank flag.
- R3: A read of $D000–$FFFF returns ROM data when `rd_rom`=1 and mapped RAM data when `rd_rom`=0. The ROM offset is the CPU address minus $D000, on 14 bits.
- R4: A write to $D000–$FFFF reaches RAM only when `wr_prot`=0. Otherwise no RAM write strobe is issued and RAM keeps its contents, including RAM under ROM.
- R5: A read or write to $C080+n loads the flags on that clock edge. `bank1` = bit 3 of n. The low two bits select the rest: 00 gives RAM read with writes locked, 01 gives ROM read with writes open, 10 gives ROM read with writes locked, and 11 gives RAM read with writes open.
- R6: After reset `rd_rom`=1, `wr_prot`=0 and `bank1`=0, so a write to $FFFF updates RAM while a read of $FFFF still returns ROM.
- R7: Address bit 2 has no effect on the soft-switch decode, and a read strobe acts exactly like a write strobe.
- R8: ROM data seen at $D000 and $FFFF is the same before and after RAM writes and bank changes.
- R9: Addresses outside $C080–$C08F and $D000–$FFFF map to the same RAM address, are never write-locked, and leave the flags unchanged.
- R10: A soft-switch access never strobes a RAM write, and a read of it returns $00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_addr | output | 16 | Physical RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM read data |
| rom_addr | output | 14 | ROM offset within the upper window |
| rom_rdata | input | 8 | ROM read data |
| rd_rom | output | 1 | Flag: upper-window reads come from ROM |
| wr_prot | output | 1 | Flag: upper-window writes are locked |
| bank1 | output | 1 | Flag: bank 1 backs $D000–$DFFF |

## Verification
The bench first writes distinct bytes through both banks and at $FFFF, then inspects the physical RAM. This shows whether bank 1 really lands in the $C000 page, whether bank 2 and $E000 and above stay in place, and whether a locked write leaves RAM untouched. Reads of $D000 and $FFFF are repeated under each read source, which separates ROM data from the RAM hidden beneath it. All sixteen soft-switch addresses are then applied in turn, alternating read and write strobes. Pairs that differ only in bit 2 must give identical flags. Accesses just outside the switch group ($C07F, $C090) and in low RAM confirm that nothing there moves the flags or is locked.

// File: rtl/umc_pkg.sv
package umc_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int ROM_AW = 14;
  localparam int PAGE_W = 4;

  localparam logic [ADDR_W-1:0] SS_BASE  = 16'hC080;
  localparam logic [ADDR_W-1:0] WIN_BASE = 16'hD000;
  localparam logic [PAGE_W-1:0] ALT_PAGE = 4'hC;
  localparam int OFF_W = ADDR_W - PAGE_W;

  typedef struct packed {
    logic rd_rom;
    logic wr_prot;
    logic bank1;
  } umc_cfg_t;

  localparam umc_cfg_t CFG_RESET = '{rd_rom: 1'b1, wr_prot: 1'b0, bank1: 1'b0};

  // Address lies in the 16-location soft-switch group
  function automatic logic in_switch(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:4] == SS_BASE[ADDR_W-1:4];
  endfunction

  // Address lies in the upper window that ROM can overlay
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a >= WIN_BASE;
  endfunction

  // Address lies in the banked page
  function automatic logic in_bank_page(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W];
  endfunction

  // Soft-switch decode: bit 3 picks the bank, bits 1:0 pick source and lock
  function automatic umc_cfg_t decode_switch(input logic [ADDR_W-1:0] a);
    umc_cfg_t c;
    c.bank1   = a[3];
    c.rd_rom  = a[1] ^ a[0];
    c.wr_prot = ~a[0];
    return c;
  endfunction

  // Physical RAM address for a CPU address
  function automatic logic [ADDR_W-1:0] phys_addr(input logic [ADDR_W-1:0] a,
                                                  input logic b1);
    if (in_bank_page(a) && b1) return {ALT_PAGE, a[OFF_W-1:0]};
    return a;
  endfunction

endpackage

// File: rtl/umc_switch_reg.sv
module umc_switch_reg
  import umc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output umc_cfg_t          cfg
);

  logic load;
  assign load = strobe && in_switch(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= CFG_RESET;
    else if (load) cfg <= decode_switch(addr);
  end

endmodule

// File: rtl/umc_addr_map.sv
module umc_addr_map
  import umc_pkg::*;
(
  input  logic              [ADDR_W-1:0] addr,
  input  logic                           wr,
  input  umc_cfg_t                       cfg,
  output logic              [ADDR_W-1:0] ram_addr,
  output logic              [ROM_AW-1:0] rom_addr,
  output logic                           ram_we,
  output logic                           ss_hit,
  output logic                           win_hit,
  output logic                           wr_blocked
);

  logic [ADDR_W-1:0] rom_full;

  assign ss_hit     = in_switch(addr);
  assign win_hit    = in_window(addr);
  assign wr_blocked = win_hit && cfg.wr_prot;
  assign ram_addr   = phys_addr(addr, cfg.bank1);
  assign rom_full   = addr - WIN_BASE;
  assign rom_addr   = rom_full[ROM_AW-1:0];
  assign ram_we     = wr && !ss_hit && !wr_blocked;

endmodule

// File: rtl/umc_read_mux.sv
module umc_read_mux
  import umc_pkg::*;
(
  input  logic              ss_hit,
  input  logic              win_hit,
  input  logic              rd_rom,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    if (ss_hit)                rdata = '0;
    else if (win_hit && rd_rom) rdata = rom_rdata;
    else                       rdata = ram_rdata;
  end

endmodule

// File: rtl/upper_mem_ctrl.sv
module upper_mem_ctrl
  import umc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              rd_rom,
  output logic              wr_prot,
  output logic              bank1
);

  umc_cfg_t cfg;
  logic     ss_hit;
  logic     win_hit;
  logic     wr_blocked;
  logic     access;

  assign access = cpu_rd || cpu_wr;

  umc_switch_reg u_switch (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (cpu_addr),
    .strobe (access),
    .cfg    (cfg)
  );

  umc_addr_map u_map (
    .addr       (cpu_addr),
    .wr         (cpu_wr),
    .cfg        (cfg),
    .ram_addr   (ram_addr),
    .rom_addr   (rom_addr),
    .ram_we     (ram_we),
    .ss_hit     (ss_hit),
    .win_hit    (win_hit),
    .wr_blocked (wr_blocked)
  );

  umc_read_mux u_mux (
    .ss_hit    (ss_hit),
    .win_hit   (win_hit),
    .rd_rom    (cfg.rd_rom),
    .ram_rdata (ram_rdata),
    .rom_rdata (rom_rdata),
    .rdata     (cpu_rdata)
  );

  assign ram_wdata = cpu_wdata;
  assign rd_rom    = cfg.rd_rom;
  assign wr_prot   = cfg.wr_prot;
  assign bank1     = cfg.bank1;

endmodule

// File: rtl/umc_checker.sv
module umc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic [15:0] ram_addr,
  input logic        ram_we,
  input logic [7:0]  rom_rdata,
  input logic        rd_rom,
  input logic        wr_prot,
  input logic        bank1,
  input logic        ss_hit,
  input logic        win_hit,
  input logic        wr_blocked
);

  // R6: flags come out of reset in the ROM-read, write-open, bank-2 state
  p_reset_state_r6: assert property (@(posedge clk)
    !rst_n |=> (rd_rom && !wr_prot && !bank1));

  // R5: a soft-switch access loads the flags from the address bits
  p_switch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_hit && (cpu_rd || cpu_wr)) |=>
      (bank1 == $past(cpu_addr[3])) &&
      (rd_rom == ($past(cpu_addr[1]) != $past(cpu_addr[0]))) &&
      (wr_prot == !$past(cpu_addr[0])));

  // R9: without a soft-switch access the flags hold
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_hit && (cpu_rd || cpu_wr)) |=> $stable({rd_rom, wr_prot, bank1}));

  // R4: a locked upper-window write never reaches RAM
  p_lock_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && wr_blocked) |-> !ram_we);

  // R1: bank 1 relocates the banked page to the $C000 page
  p_bank1_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:12] == 4'hD && bank1) |-> (ram_addr == {4'hC, cpu_addr[11:0]}));

  // R2: the top of the window is never relocated
  p_top_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && cpu_addr[15:12] != 4'hD) |-> (ram_addr == cpu_addr));

  // R3: ROM-sourced upper reads return ROM data
  p_rom_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && win_hit && rd_rom) |-> (cpu_rdata == rom_rdata));

  // R10: soft-switch accesses never write RAM and read as zero
  p_switch_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_hit |-> (!ram_we && cpu_rdata == 8'h00));

endmodule

bind upper_mem_ctrl umc_checker i_umc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .cpu_rdata  (cpu_rdata),
  .ram_addr   (ram_addr),
  .ram_we     (ram_we),
  .rom_rdata  (rom_rdata),
  .rd_rom     (rd_rom),
  .wr_prot    (wr_prot),
  .bank1      (bank1),
  .ss_hit     (ss_hit),
  .win_hit    (win_hit),
  .wr_blocked (wr_blocked)
);

// File: tb/test_upper_mem_ctrl.sv
module test_upper_mem_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_we;
  logic [7:0]  ram_rdata;
  logic [13:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic        rd_rom, wr_prot, bank1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  upper_mem_ctrl i_upper_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .rd_rom(rd_rom), .wr_prot(wr_prot), .bank1(bank1)
  );

  // Physical RAM model (sparse) and ROM model
  logic [7:0] ram_m [logic [15:0]];
  logic [7:0] exp_mem [logic [15:0]];

  function automatic logic [7:0] ram_get(input logic [15:0] a);
    return ram_m.exists(a) ? ram_m[a] : 8'h00;
  endfunction

  function automatic logic [7:0] exp_get(input logic [15:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction

  always @(posedge clk) if (ram_we) ram_m[ram_addr] = ram_wdata;
  always @(*) ram_rdata = ram_get(ram_addr);
  always @(*) rom_rdata = (rom_addr[7:0] ^ {2'b00, rom_addr[13:8]}) + 8'h6F;

  // Expected ROM byte for a CPU address in the upper window
  function automatic logic [7:0] rom_exp(input logic [15:0] a);
    logic [15:0] off;
    off = a - 16'hD000;
    return (off[7:0] ^ {2'b00, off[13:8]}) + 8'h6F;
  endfunction

  // Bench copy of the configuration, kept from the requirements
  logic m_rom = 1'b1, m_prot = 1'b0, m_b1 = 1'b0;

  function automatic logic is_sw(input logic [15:0] a);
    return a >= 16'hC080 && a <= 16'hC08F;
  endfunction

  function automatic logic [15:0] t_phys(input logic [15:0] a);
    if (a >= 16'hD000 && a <= 16'hDFFF && m_b1) return 16'hC000 + (a - 16'hD000);
    return a;
  endfunction

  task automatic apply_switch(input logic [15:0] a);
    m_b1 = a[3];
    case (a[1:0])
      2'b00: begin m_rom = 1'b0; m_prot = 1'b1; end
      2'b01: begin m_rom = 1'b1; m_prot = 1'b0; end
      2'b10: begin m_rom = 1'b1; m_prot = 1'b1; end
      default: begin m_rom = 1'b0; m_prot = 1'b0; end
    endcase
  endtask

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues for read data
  logic [7:0]  exp_q  [$];
  logic [15:0] addr_q [$];
  string       tag_q  [$];

  always @(negedge clk) begin
    if (cpu_rd) begin
      if (exp_q.size() == 0) begin
        check("SB", "unexpected read", 16'(cpu_rdata), 16'hFFFF);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        void'(addr_q.pop_front());
        check(t, "read data", 16'(cpu_rdata), 16'(e));
      end
    end
  end

  task automatic drive(input logic rd, input logic wr, input logic [15:0] a,
                       input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
    @(posedge clk); #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    if (is_sw(a)) apply_switch(a);
    else if (!(a >= 16'hD000 && m_prot)) exp_mem[t_phys(a)] = d;
    drive(1'b0, 1'b1, a, d);
  endtask

  task automatic do_rd(input logic [15:0] a, input string tag);
    logic [7:0] e;
    if (is_sw(a))                   e = 8'h00;
    else if (a >= 16'hD000 && m_rom) e = rom_exp(a);
    else                            e = exp_get(t_phys(a));
    exp_q.push_back(e); addr_q.push_back(a); tag_q.push_back(tag);
    if (is_sw(a)) apply_switch(a);
    drive(1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic check_flags(input string tag);
    check(tag, "rd_rom",  16'(rd_rom),  16'(m_rom));
    check(tag, "wr_prot", 16'(wr_prot), 16'(m_prot));
    check(tag, "bank1",   16'(bank1),   16'(m_b1));
  endtask

  task automatic check_ram(input logic [15:0] pa, input string tag);
    check(tag, $sformatf("phys RAM %h", pa), 16'(ram_get(pa)), 16'(exp_get(pa)));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R6: reset configuration
    check_flags("R6");

    // R3 R8: ROM visible at both ends of the window
    do_rd(16'hD000, "R8");
    do_rd(16'hFFFF, "R3");

    // R6: write to $FFFF lands in RAM, read still ROM
    do_wr(16'hFFFF, 8'hFF);
    do_rd(16'hFFFF, "R6");
    check_ram(16'hFFFF, "R6");

    // R1: bank 2 write stays at $D000
    do_wr(16'hD000, 8'hFE);
    check_ram(16'hD000, "R1");
    check_ram(16'hC000, "R1");

    // R5: switch to bank 1, RAM read, writes open
    do_wr(16'hC08B, 8'h5A);
    check_flags("R5");
    do_wr(16'hD000, 8'hFD);
    check_ram(16'hC000, "R1");
    check_ram(16'hD000, "R1");
    do_rd(16'hD000, "R1");

    // R2: top of window unaffected by bank
    do_wr(16'hE123, 8'h77);
    check_ram(16'hE123, "R2");
    do_rd(16'hE123, "R2");

    // R1: back to bank 2 by a read strobe
    do_rd(16'hC083, "R10");
    check_flags("R7");
    do_rd(16'hD000, "R1");
    do_rd(16'hE123, "R2");

    // R4: lock writes, bank 1
    do_wr(16'hC088, 8'h00);
    check_flags("R5");
    do_wr(16'hD000, 8'h01);
    do_wr(16'hFFFF, 8'h02);
    check_ram(16'hC000, "R4");
    check_ram(16'hD000, "R4");
    check_ram(16'hFFFF, "R4");
    do_rd(16'hFFFF, "R4");

    // R9: low RAM is never locked and leaves the flags alone
    do_wr(16'h1234, 8'hA5);
    check_ram(16'h1234, "R9");
    do_rd(16'h1234, "R9");
    do_wr(16'hC07F, 8'h11);
    do_rd(16'hC090, "R9");
    check_flags("R9");

    // R8: ROM unchanged after writes and bank moves
    do_rd(16'hC08A, "R10");
    do_rd(16'hD000, "R8");
    do_rd(16'hFFFF, "R8");

    // R5 R7: sweep every soft-switch address, alternating strobes
    for (int i = 0; i < 16; i++) begin
      if (i % 2 == 0) do_wr(16'hC080 + 16'(i), 8'hC3);
      else            do_rd(16'hC080 + 16'(i), "R10");
      check_flags((i >= 4 && i < 8) || i >= 12 ? "R7" : "R5");
    end

    // R10: soft-switch writes never reach RAM
    check_ram(16'hC080, "R10");
    check_ram(16'hC08E, "R10");

    // R3: RAM-sourced upper read shows RAM under the window
    do_wr(16'hC083, 8'h00);
    do_rd(16'hFFFF, "R3");
    do_rd(16'hD000, "R3");

    repeat (2) @(posedge clk);
    check("SB", "pending reads", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule